// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a byte-wide user stream into a serial HDLC bit stream, one line bit per clock on the serial line clock. Between frames it sends the flag pattern continuously. For each byte slot it raises a one-clock demand strobe. On that same clock it samples the send-message and send-FCS controls, the data bus and the CRC-size setting. These values choose the content of the next slot: a payload byte, the first frame check sequence byte, an abort byte or another flag.

The user starts a frame by holding send-message high at a strobe and supplies one byte per strobe. The user then asserts send-FCS together with send-message at the next strobe, and the block appends a 16-bit or 32-bit FCS. The user should hold send-FCS for two or four slots. The block counts the FCS bytes by itself, and the controls seen during those slots have no effect. If send-FCS is high while send-message is low inside a frame, the frame is aborted. Payload and FCS bits are zero-stuffed. Each stuffed bit stretches the slot by one clock, so the strobe rate can fall below one in eight clocks.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While rst_ni is low, byte_req_o and ser_valid_o are low and ser_data_o is 0. From the first clock edge after reset is released, ser_valid_o stays high. From the following clock, the line carries back-to-back flags 0x7E, least significant bit first.
- R2: byte_req_o is high for exactly one clock, during the last bit of each byte slot. Inputs are sampled only at the clock edge that ends that cycle, so input values at any other time have no effect on the output.
- R3: A frame starts when send_msg_i is high at a strobe while the block is idle or is sending a closing flag. Each data_i byte taken at a strobe is sent least significant bit first in the following slot.
- R4: Outside a frame, a strobe with send_msg_i low loads a flag, whatever the values of data_i and send_fcs_i.
- R5: After five consecutive one bits of payload or FCS, a 0 bit is inserted. The count of ones continues across byte boundaries. The inserted bit delays the rest of the stream, including the next strobe, by one clock.
- R6: Flag and abort bytes are never zero-stuffed, and they reset the count of consecutive ones.
- R7: Inside a frame, a strobe with send_msg_i and send_fcs_i both high starts the FCS. It is sent over 2 slots for CRC-16 and 4 slots for CRC-32, and the inputs sampled at the strobes inside the FCS have no effect.
- R8: CRC-16 uses polynomial 0x1021 and CRC-32 uses 0x04C11DB7. Both are processed LSB first from an all-ones preset, and the complemented remainder is sent low-order byte first, each byte LSB first. CRC-16 over ASCII "123456789" gives FCS 0x906E, and CRC-32 gives 0xCBF43926.
- R9: crc32_sel_i (1 = CRC-32) is sampled only at the strobe that starts a frame. Changes to it later in the frame do not change that frame's FCS.
- R10: Exactly one closing flag follows the last FCS byte. A frame may start at the strobe that ends that flag, and inputs sampled at the strobe that ends the FCS have no effect.
- R11: Inside a frame, a strobe with send_fcs_i high and send_msg_i low sends the abort byte 0xFF. After it comes at least one flag, whatever the inputs are at the strobe ending the abort byte.
- R12: Inside a frame, a strobe with send_msg_i and send_fcs_i both low (underrun) also sends the abort byte 0xFF and then returns to flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial line clock, one line bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| crc32_sel_i | input | 1 | FCS size for the next frame: 1 = CRC-32, 0 = CRC-16 |
| send_msg_i | input | 1 | Supply a payload byte at this strobe |
| send_fcs_i | input | 1 | Close the frame with the FCS (with send_msg_i) or abort it (without) |
| data_i | input | 8 | Payload byte, sampled at a strobe |
| byte_req_o | output | 1 | One-clock byte demand strobe |
| ser_data_o | output | 1 | Serial line bit |
| ser_valid_o | output | 1 | Line bit is valid |

## Verification
The hardest case to reach from the ports is a stuffed bit that falls exactly at a byte boundary. When this happens the strobe moves by one clock, and that can occur right before an FCS byte or right before a closing flag. The stimulus sends runs of 0xFF and 0x3F/0xF8 bytes in frames of both CRC sizes, so the count of ones crosses slot edges and the FCS itself is stuffed. A behavioural reference model follows every bit and strobe. Between strobes the bench drives random values on all inputs. At the strobes that must be ignored (inside an FCS, closing flag, after an abort) it drives send_msg_i high, so any wrong sampling changes the line.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned CRC16_W        = 16;
  localparam int unsigned CRC32_W        = 32;
  localparam int unsigned CRC_MAX_W      = CRC32_W;
  localparam int unsigned FCS16_BYTES    = CRC16_W / BYTE_W;
  localparam int unsigned FCS32_BYTES    = CRC32_W / BYTE_W;
  localparam int unsigned STUFF_RUN      = 5;
  localparam logic [CRC16_W-1:0] CRC16_POLY_REF = 16'h8408;
  localparam logic [CRC32_W-1:0] CRC32_POLY_REF = 32'hEDB88320;
  localparam logic [BYTE_W-1:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [BYTE_W-1:0]  ABORT_BYTE = 8'hFF;

  typedef enum logic [1:0] {K_FLAG, K_DATA, K_FCS, K_ABORT} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_BODY, S_FCS, S_CLOSE, S_ABORT} slot_e;

  function automatic logic is_body(kind_e k);
    return (k == K_DATA) || (k == K_FCS);
  endfunction
endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit import hdlc_tx_pkg::*; #(
  parameter int unsigned       W        = 16,
  parameter logic [W-1:0]      POLY_REF = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [W-1:0]      crc_o
);
  logic [W-1:0] crc_q;

  function automatic logic [W-1:0] step_byte(logic [W-1:0] c, logic [BYTE_W-1:0] d);
    logic [W-1:0] r;
    logic         fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ POLY_REF;
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (upd_i)  crc_q <= step_byte(init_i ? '1 : crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic body_i,
  input  logic bit_i,
  output logic stuff_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  logic [CNT_W-1:0] ones_q;

  assign stuff_o = (ones_q == CNT_W'(RUN_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (adv_i) begin
      if (stuff_o)              ones_q <= '0;
      else if (body_i && bit_i) ones_q <= ones_q + 1'b1;
      else                      ones_q <= '0;
    end
  end
endmodule

// File: rtl/hdlc_slot_ctrl.sv
module hdlc_slot_ctrl import hdlc_tx_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  slot_end_i,
  input  logic  send_msg_i,
  input  logic  send_fcs_i,
  input  logic  crc32_sel_i,
  output kind_e kind_o,
  output logic  frame_start_o,
  output logic  data_take_o,
  output logic  fcs_first_o,
  output logic  len32_o,
  output slot_e state_o
);
  localparam int unsigned LEFT_W = $clog2(FCS32_BYTES);

  slot_e             st_q, st_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              len32_q;
  logic              fs, take, first;

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    kind_o = K_FLAG;
    fs     = 1'b0;
    take   = 1'b0;
    first  = 1'b0;
    unique case (st_q)
      S_IDLE, S_CLOSE: begin
        if (send_msg_i) begin
          kind_o = K_DATA;
          st_d   = S_BODY;
          fs     = 1'b1;
          take   = 1'b1;
        end else begin
          st_d   = S_IDLE;
        end
      end
      S_ABORT: st_d = S_IDLE;
      S_BODY: begin
        if (send_msg_i && send_fcs_i) begin
          kind_o = K_FCS;
          st_d   = S_FCS;
          first  = 1'b1;
          left_d = len32_q ? LEFT_W'(FCS32_BYTES - 1) : LEFT_W'(FCS16_BYTES - 1);
        end else if (send_msg_i) begin
          kind_o = K_DATA;
          take   = 1'b1;
        end else begin
          // explicit abort or underrun
          kind_o = K_ABORT;
          st_d   = S_ABORT;
        end
      end
      S_FCS: begin
        if (left_q != '0) begin
          kind_o = K_FCS;
          left_d = left_q - 1'b1;
        end else begin
          st_d   = S_CLOSE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      left_q  <= '0;
      len32_q <= 1'b0;
    end else if (slot_end_i) begin
      st_q   <= st_d;
      left_q <= left_d;
      if (fs) len32_q <= crc32_sel_i;
    end
  end

  assign frame_start_o = slot_end_i && fs;
  assign data_take_o   = slot_end_i && take;
  assign fcs_first_o   = first;
  assign len32_o       = len32_q;
  assign state_o       = st_q;
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer import hdlc_tx_pkg::*; #(
  parameter int unsigned RUN_LEN = STUFF_RUN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              crc32_sel_i,
  input  logic              send_msg_i,
  input  logic              send_fcs_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              byte_req_o,
  output logic              ser_data_o,
  output logic              ser_valid_o
);
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam int unsigned HOLD_W = CRC_MAX_W - BYTE_W;

  logic                 run_q;
  logic [BYTE_W-1:0]    sh_q;
  logic [CNT_W-1:0]     bcnt_q;
  kind_e                kind_q;
  logic [HOLD_W-1:0]    hold_q;

  logic                 stuff, body_bit, slot_end;
  kind_e                load_kind;
  logic                 frame_start, data_take, fcs_first, len32;
  slot_e                slot_state;
  logic [CRC16_W-1:0]   crc16;
  logic [CRC32_W-1:0]   crc32;
  logic [CRC_MAX_W-1:0] fcs_word;

  hdlc_zero_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (run_q),
    .body_i (is_body(kind_q)),
    .bit_i  (sh_q[0]),
    .stuff_o(stuff)
  );

  assign slot_end = run_q && !stuff && (bcnt_q == CNT_W'(BYTE_W - 1));
  assign body_bit = run_q && !stuff && is_body(kind_q);

  hdlc_slot_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_end_i   (slot_end),
    .send_msg_i   (send_msg_i),
    .send_fcs_i   (send_fcs_i),
    .crc32_sel_i  (crc32_sel_i),
    .kind_o       (load_kind),
    .frame_start_o(frame_start),
    .data_take_o  (data_take),
    .fcs_first_o  (fcs_first),
    .len32_o      (len32),
    .state_o      (slot_state)
  );

  hdlc_crc_unit #(.W(CRC16_W), .POLY_REF(CRC16_POLY_REF)) u_crc16 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(frame_start),
    .upd_i (data_take),
    .data_i(data_i),
    .crc_o (crc16)
  );

  hdlc_crc_unit #(.W(CRC32_W), .POLY_REF(CRC32_POLY_REF)) u_crc32 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(frame_start),
    .upd_i (data_take),
    .data_i(data_i),
    .crc_o (crc32)
  );

  assign fcs_word = len32 ? ~crc32 : {{(CRC_MAX_W - CRC16_W){1'b0}}, ~crc16};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sh_q   <= FLAG_BYTE;
      bcnt_q <= '0;
      kind_q <= K_FLAG;
      hold_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (slot_end) begin
        bcnt_q <= '0;
        kind_q <= load_kind;
        unique case (load_kind)
          K_FLAG:  sh_q <= FLAG_BYTE;
          K_ABORT: sh_q <= ABORT_BYTE;
          K_DATA:  sh_q <= data_i;
          K_FCS: begin
            if (fcs_first) {hold_q, sh_q} <= fcs_word;
            else begin
              sh_q   <= hold_q[BYTE_W-1:0];
              hold_q <= hold_q >> BYTE_W;
            end
          end
          default: sh_q <= FLAG_BYTE;
        endcase
      end else if (run_q && !stuff) begin
        sh_q   <= sh_q >> 1;
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign byte_req_o  = slot_end;
  assign ser_data_o  = stuff ? 1'b0 : sh_q[0];
  assign ser_valid_o = run_q;
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk import hdlc_tx_pkg::*; #(
  parameter int unsigned RUN_LEN = STUFF_RUN
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  byte_req_o,
  input logic  ser_data_o,
  input logic  ser_valid_o,
  input logic  send_msg_i,
  input logic  body_bit_i,
  input kind_e kind_i,
  input slot_e state_i
);
  logic [3:0] ones_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_run_q <= '0;
    else if (ser_valid_o) begin
      if (body_bit_i && ser_data_o) ones_run_q <= (ones_run_q == 4'hF) ? ones_run_q : ones_run_q + 1'b1;
      else                          ones_run_q <= '0;
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |=> !byte_req_o);

  // R1
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |=> ser_valid_o);

  // R1
  req_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> ser_valid_o);

  // R5
  stuff_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_run_q == 4'(RUN_LEN)) |-> !ser_data_o);

  // R11
  abort_then_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(kind_i) == K_ABORT && kind_i != K_ABORT) |-> (kind_i == K_FLAG));

  // R10
  fcs_then_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(kind_i) == K_FCS && kind_i != K_FCS) |-> (kind_i == K_FLAG));

  // R4
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_req_o && !send_msg_i && state_i == S_IDLE) |=> (kind_i == K_FLAG));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.RUN_LEN(RUN_LEN)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_req_o (byte_req_o),
  .ser_data_o (ser_data_o),
  .ser_valid_o(ser_valid_o),
  .send_msg_i (send_msg_i),
  .body_bit_i (body_bit),
  .kind_i     (kind_q),
  .state_i    (slot_state)
);

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 30000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       crc32_sel_i = 1'b0;
  logic       send_msg_i = 1'b0;
  logic       send_fcs_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       byte_req_o, ser_data_o, ser_valid_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_framer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .crc32_sel_i(crc32_sel_i),
    .send_msg_i (send_msg_i),
    .send_fcs_i (send_fcs_i),
    .data_i     (data_i),
    .byte_req_o (byte_req_o),
    .ser_data_o (ser_data_o),
    .ser_valid_o(ser_valid_o)
  );

  typedef struct packed {
    logic       msg;
    logic       fcs;
    logic       sel;
    logic [7:0] d;
  } act_t;

  act_t       script[$];
  logic [7:0] fb[$];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  // reference model state
  int          m_state = 0;   // 0 idle, 1 body, 2 fcs, 3 close, 4 abort
  int          m_kind  = 0;   // 0 flag, 1 data, 2 fcs, 3 abort
  logic [7:0]  m_byte  = 8'h7E;
  int          m_bit   = 0;
  int          m_ones  = 0;
  bit          m_w32   = 0;
  logic [31:0] m_crc   = '1;
  logic [7:0]  m_fcs[$];
  string       m_tag   = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d, input bit w32);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      bit f = r[0] ^ d[i];
      r = r >> 1;
      if (f) r = r ^ (w32 ? 32'hEDB88320 : 32'h0000_8408);
    end
    return r;
  endfunction

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) script.push_back({1'b0, 1'($urandom), 1'($urandom), 8'($urandom)});
  endtask

  // ending: 0 FCS held, 1 FCS dropped early, 2 abort, 3 underrun
  task automatic push_frame(input bit w32, input int ending);
    int n = w32 ? 4 : 2;
    for (int i = 0; i < fb.size(); i++)
      script.push_back({1'b1, 1'b0, (i == 0) ? w32 : 1'($urandom), fb[i]});
    case (ending)
      0: for (int i = 0; i < n; i++) script.push_back({1'b1, 1'b1, 1'($urandom), 8'($urandom)});
      1: begin
        script.push_back({1'b1, 1'b1, 1'($urandom), 8'($urandom)});
        for (int i = 1; i < n; i++) script.push_back({1'b0, 1'b0, 1'($urandom), 8'($urandom)});
      end
      2: script.push_back({1'b0, 1'b1, 1'($urandom), 8'($urandom)});
      default: script.push_back({1'b0, 1'b0, 1'($urandom), 8'($urandom)});
    endcase
    // filler at the closing-flag / post-abort strobe: must be ignored
    script.push_back({1'b1, 1'($urandom), 1'($urandom), 8'($urandom)});
  endtask

  task automatic load(input int kind, input logic [7:0] b, input string tag);
    m_kind = kind;
    m_byte = b;
    m_tag  = tag;
  endtask

  task automatic next_slot(input act_t a);
    case (m_state)
      0, 3: begin
        if (a.msg) begin
          m_w32 = a.sel;
          m_crc = crc_upd(m_w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF, a.d, m_w32);
          load(1, a.d, "R3");
          m_state = 1;
        end else begin
          load(0, 8'h7E, "R4");
          m_state = 0;
        end
      end
      4: begin
        load(0, 8'h7E, "R11");
        m_state = 0;
      end
      1: begin
        if (a.msg && a.fcs) begin
          logic [31:0] f = ~m_crc;
          for (int k = 0; k < (m_w32 ? 4 : 2); k++) m_fcs.push_back(f[8*k +: 8]);
          load(2, m_fcs.pop_front(), m_w32 ? "R7 R9" : "R7 R8");
          m_state = 2;
        end else if (a.msg) begin
          m_crc = crc_upd(m_crc, a.d, m_w32);
          load(1, a.d, "R3");
        end else if (a.fcs) begin
          load(3, 8'hFF, "R6 R11");
          m_state = 4;
        end else begin
          load(3, 8'hFF, "R6 R12");
          m_state = 4;
        end
      end
      default: begin
        if (m_fcs.size() > 0) load(2, m_fcs.pop_front(), m_w32 ? "R7 R9" : "R7 R8");
        else begin
          load(0, 8'h7E, "R10");
          m_state = 3;
        end
      end
    endcase
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int   cyc = 0;
    int   tail = 0;
    logic [31:0] c;

    // R8: reference CRC vectors
    c = 32'h0000_FFFF;
    for (int i = 0; i < 9; i++) c = crc_upd(c, 8'h31 + 8'(i), 1'b0);
    chk((~c & 32'hFFFF) == 32'h906E, "R8 crc16 vector", ~c & 32'hFFFF, 32'h906E);
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 9; i++) c = crc_upd(c, 8'h31 + 8'(i), 1'b1);
    chk(~c == 32'hCBF43926, "R8 crc32 vector", ~c, 32'hCBF43926);

    push_idle(3);
    fb = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    push_frame(1'b0, 0);
    fb = {8'hFF, 8'hFF, 8'hFF, 8'h3F, 8'hF8, 8'h7E};
    push_frame(1'b1, 1);
    fb = {8'h7E, 8'h7D, 8'hA5};
    push_frame(1'b0, 2);
    fb = {8'hF0, 8'h0F};
    push_frame(1'b1, 3);
    fb = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    push_frame(1'b0, 0);
    push_idle(2);
    fb = {8'h00, 8'hFC};
    push_frame(1'b1, 0);
    push_idle(3);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      data_i = 8'($urandom);
      send_msg_i = 1'($urandom);
      chk(byte_req_o == 1'b0, "R1 req in reset", 32'(byte_req_o), 0);
      chk(ser_valid_o == 1'b0, "R1 valid in reset", 32'(ser_valid_o), 0);
      chk(ser_data_o == 1'b0, "R1 data in reset", 32'(ser_data_o), 0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);

    while (tail < 60 && cyc < MAX_CYCLES) begin
      bit   e_stuff, e_bit, e_req;
      act_t a;
      @(negedge clk);
      cyc++;
      e_stuff = (m_ones == 5);
      e_bit   = e_stuff ? 1'b0 : m_byte[m_bit];
      e_req   = !e_stuff && (m_bit == 7);
      chk(ser_valid_o == 1'b1, "R1 valid", 32'(ser_valid_o), 1);
      chk(byte_req_o == e_req, "R2 strobe", 32'(byte_req_o), 32'(e_req));
      chk(ser_data_o == e_bit, e_stuff ? "R5 stuffed bit" : m_tag, 32'(ser_data_o), 32'(e_bit));

      if (e_req) begin
        if (script.size() > 0) a = script.pop_front();
        else begin
          a = {1'b0, 1'b0, 1'b0, 8'($urandom)};
          tail++;
        end
      end else begin
        a = act_t'($urandom);
        if (script.size() == 0) tail++;
      end
      send_msg_i  = a.msg;
      send_fcs_i  = a.fcs;
      crc32_sel_i = a.sel;
      data_i      = a.d;

      if (e_stuff) m_ones = 0;
      else begin
        if (m_kind == 1 || m_kind == 2) m_ones = e_bit ? m_ones + 1 : 0;
        else m_ones = 0;
        if (m_bit == 7) begin
          next_slot(a);
          m_bit = 0;
        end else m_bit++;
      end
    end
    chk(cyc < MAX_CYCLES, "R2 stream drained", 32'(cyc), MAX_CYCLES);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule